// File: doc/BRIEF.md
# Cipher Operand Register File with Start Triggers

This block sits between a 32-bit register bus and a 128-bit block-cipher core. It holds three 128-bit operands: the key, the text block and an auxiliary buffer block. Each is written one word at a time. The text block can also take an XOR-in write through an alias window. A second alias window reads text XOR buffer for each word. Hardware can also fold the buffer into the text block when word 3 of a window is read.

A cipher run can start in three ways:
- a manual command;
- an access to word 3 of the text or alias windows;
- a write to word 3 of the buffer, which schedules a start that fires once the engine is idle.

The block tracks idle or busy and a buffer-full flag. While busy it either drops protected accesses or holds the bus with `ready_o` low, as configured. The core receives a one-cycle start pulse together with the key and the operand. It returns a one-cycle done pulse with the 128-bit result, which lands in the text block.

Top module: `aes_opr_top`

## Requirements
- R1: A command-word (addr 0x14) write with bits[1:0] = 1, 2 or 3 while idle starts a run on text, buffer, or text XOR buffer. Code 0, or any code written while busy, is ignored. `start_o` is high for exactly one cycle, in the cycle after the accepting edge, with `operand_o` valid. Status (addr 0x16) bit0 reads 1 while busy.
- R2: A `done_i` pulse while busy loads `result_i` into the text block and returns the block to idle. `done_evt_o` is high for one cycle after that edge. The key is kept.
- R3: Writing the XOR window (addr 0x08+n) sets text word n to the written data XOR its old value. Other words are unchanged.
- R4: Text (0x04+n) and buffer (0x0C+n) words read back what was written. Reading the mix window (0x10+n) returns text word n XOR buffer word n and changes neither.
- R5: Config (addr 0x15) has these fields: [3:0] auto-trigger set, [5:4] source code for automatic starts, [7:6] fold-on-read, [8] stall enable, [9] counter mode. It reads back as written. With auto bit0 set, an idle write to text or XOR word 3 starts a run. With auto bit1 set, an idle read of text or mix word 3 starts a run. Other words never start a run.
- R6: With auto bit2 set and counter mode off, every buffer word 3 write schedules a start. The start fires at once if the engine is idle, otherwise on the cycle after it becomes idle. With counter mode on, no start is scheduled.
- R7: With auto bit3 set, one buffer word 3 write schedules one start. Bit3 clears itself and status bit1 (buffer full) is set until the scheduled run takes the buffer. Later buffer word 3 writes start nothing.
- R8: Fold bit0 XORs the buffer into the text block on a read of text word 3. Fold bit1 does the same on a read of mix word 3. The read returns the value before the fold.
- R9: While busy with stall off, writes to key, text and XOR words are dropped, and reads of text and mix words return 0. Buffer accesses are treated the same way only when the buffer is full or counter mode is on.
- R10: While busy with stall on, those same accesses hold `ready_o` low until the engine is idle, and then complete.
- R11: Command bit2 clears the text block and bit3 clears the buffer, only while idle. While busy they have no effect.
- R12: Command bit4 aborts the run. The abort clears text, buffer, config, busy and the buffer-full and scheduled-start flags, and pulses `abort_o` for one cycle. A later `done_i` is ignored.
- R13: Key word k (addr 0x00+k, write-only, reads 0) drives `key_o[32k+31:32k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid when req_i and ready_o |
| ready_o | output | 1 | Access completes this cycle |
| start_o | output | 1 | One-cycle start pulse to the core |
| key_o | output | 128 | Key to the core |
| operand_o | output | 128 | Operand to the core |
| done_i | input | 1 | One-cycle completion pulse from the core |
| result_i | input | 128 | Core result |
| done_evt_o | output | 1 | One-cycle completion event |
| abort_o | output | 1 | One-cycle abort event, also stops the core |

## Verification
Register reads are combinational: read data is sampled in the same cycle the access is presented, half a cycle before the accepting edge. Register writes, folds and clears become visible at the first edge, so the bench reads them back with the next access. A start caused by a command or by a word 3 access shows on `start_o` and `operand_o` exactly one edge after the access. A start scheduled while busy shows one edge after the edge where `done_i` is taken. The bench therefore samples on the falling edge right after each accepting edge. It drives the stall case and the core completion in parallel branches, so that `ready_o` is seen low on each stalled cycle and the read data is taken on the cycle it rises.

// File: rtl/aes_opr_pkg.sv
package aes_opr_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NW = 4;
  localparam int unsigned AW = 5;
  localparam int unsigned IW = $clog2(NW);

  typedef enum logic [3:0] {
    RG_NONE, RG_KEY, RG_TXT, RG_TXX, RG_BUF, RG_MIX, RG_CMD, RG_CFG, RG_STA
  } rg_e;

  typedef struct packed {
    rg_e             rg;
    logic [IW-1:0]   idx;
    logic            last;
  } dec_t;

  typedef struct packed {
    logic       ctr_on;
    logic       stall;
    logic [1:0] fold;
    logic [1:0] src;
    logic [3:0] auto_trg;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
  localparam int unsigned CMD_ABORT = 4;
  localparam int unsigned CMD_CLRB  = 3;
  localparam int unsigned CMD_CLRT  = 2;
endpackage

// File: rtl/aes_opr_decode.sv
module aes_opr_decode
  import aes_opr_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  output dec_t          dec_o
);
  localparam int unsigned GW = AW - IW;

  always_comb begin
    dec_o.idx  = addr_i[IW-1:0];
    dec_o.last = (addr_i[IW-1:0] == IW'(NW - 1));
    dec_o.rg   = RG_NONE;
    unique case (addr_i[AW-1:IW])
      GW'(0): dec_o.rg = RG_KEY;
      GW'(1): dec_o.rg = RG_TXT;
      GW'(2): dec_o.rg = RG_TXX;
      GW'(3): dec_o.rg = RG_BUF;
      GW'(4): dec_o.rg = RG_MIX;
      GW'(5): begin
        unique case (addr_i[IW-1:0])
          IW'(0):  dec_o.rg = RG_CMD;
          IW'(1):  dec_o.rg = RG_CFG;
          IW'(2):  dec_o.rg = RG_STA;
          default: dec_o.rg = RG_NONE;
        endcase
      end
      default: dec_o.rg = RG_NONE;
    endcase
  end
endmodule

// File: rtl/aes_opr_store.sv
module aes_opr_store
  import aes_opr_pkg::*;
#(
  parameter  int unsigned DATA_W  = DW,
  parameter  int unsigned N_WORDS = NW,
  localparam int unsigned BLK_W   = DATA_W * N_WORDS,
  localparam int unsigned IDX_W   = $clog2(N_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              key_we_i,
  input  logic              txt_we_i,
  input  logic              txx_we_i,
  input  logic              buf_we_i,
  input  logic              fold_i,
  input  logic              txt_clr_i,
  input  logic              buf_clr_i,
  input  logic              res_ld_i,
  input  logic [BLK_W-1:0]  res_i,
  output logic [BLK_W-1:0]  key_o,
  output logic [BLK_W-1:0]  txt_o,
  output logic [BLK_W-1:0]  buf_o,
  output logic [BLK_W-1:0]  txt_nxt_o,
  output logic [BLK_W-1:0]  buf_nxt_o
);
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    localparam int unsigned LO = w * DATA_W;
    logic              sel;
    logic [DATA_W-1:0] k_q, t_q, b_q, t_nxt, b_nxt;

    assign sel = (idx_i == IDX_W'(w));

    always_comb begin
      t_nxt = t_q;
      if (txt_clr_i)              t_nxt = '0;
      else if (res_ld_i)          t_nxt = res_i[LO +: DATA_W];
      else if (fold_i)            t_nxt = t_q ^ b_q;
      else if (txt_we_i && sel)   t_nxt = wdata_i;
      else if (txx_we_i && sel)   t_nxt = t_q ^ wdata_i;
    end

    always_comb begin
      b_nxt = b_q;
      if (buf_clr_i)              b_nxt = '0;
      else if (buf_we_i && sel)   b_nxt = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        k_q <= '0;
        t_q <= '0;
        b_q <= '0;
      end else begin
        if (key_we_i && sel) k_q <= wdata_i;
        t_q <= t_nxt;
        b_q <= b_nxt;
      end
    end

    assign key_o[LO +: DATA_W]     = k_q;
    assign txt_o[LO +: DATA_W]     = t_q;
    assign buf_o[LO +: DATA_W]     = b_q;
    assign txt_nxt_o[LO +: DATA_W] = t_nxt;
    assign buf_nxt_o[LO +: DATA_W] = b_nxt;
  end

  assert_txt_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txt_clr_i |=> (txt_o == '0));
  assert_buf_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_clr_i |=> (buf_o == '0));
endmodule

// File: rtl/aes_opr_ctrl.sv
module aes_opr_ctrl
  import aes_opr_pkg::*;
#(
  parameter int unsigned BLK_W = DW * NW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  rg_e              rg_i,
  input  logic             last_i,
  input  logic [CFG_W-1:0] cmd_i,
  input  logic             done_i,
  input  logic [BLK_W-1:0] txt_nxt_i,
  input  logic [BLK_W-1:0] buf_nxt_i,
  output logic             ready_o,
  output logic             guard_o,
  output logic             key_we_o,
  output logic             txt_we_o,
  output logic             txx_we_o,
  output logic             buf_we_o,
  output logic             fold_o,
  output logic             txt_clr_o,
  output logic             buf_clr_o,
  output logic             res_ld_o,
  output logic             start_o,
  output logic [BLK_W-1:0] operand_o,
  output logic             done_evt_o,
  output logic             abort_o,
  output logic             busy_o,
  output logic             full_o,
  output cfg_t             cfg_o
);
  logic busy_q, pend_q, full_q, start_q, done_q, abort_q;
  cfg_t cfg_q;
  logic [BLK_W-1:0] opnd_q, opnd_d;

  logic core_rg, guarded, acc, ok, wr, rd, cmd_wr;
  logic abort_w, man_ok, acc_trig, buf3, sched_rep, sched_one, fire_pend, go;
  logic [1:0] src_sel;

  assign core_rg = (rg_i inside {RG_KEY, RG_TXT, RG_TXX, RG_MIX});
  assign guarded = busy_q && (core_rg || (rg_i == RG_BUF && (full_q || cfg_q.ctr_on)));
  assign ready_o = !(req_i && guarded && cfg_q.stall);
  assign acc     = req_i && ready_o;
  assign ok      = acc && !guarded;
  assign wr      = ok && we_i;
  assign rd      = ok && !we_i;
  assign cmd_wr  = wr && (rg_i == RG_CMD);

  assign abort_w  = cmd_wr && cmd_i[CMD_ABORT];
  assign man_ok   = cmd_wr && !busy_q && (cmd_i[1:0] != 2'd0) && !abort_w;
  assign acc_trig = !busy_q && (cfg_q.src != 2'd0) && last_i &&
                    ((cfg_q.auto_trg[0] && wr && (rg_i inside {RG_TXT, RG_TXX})) ||
                     (cfg_q.auto_trg[1] && rd && (rg_i inside {RG_TXT, RG_MIX})));
  assign buf3      = wr && (rg_i == RG_BUF) && last_i;
  assign sched_rep = buf3 && cfg_q.auto_trg[2] && !cfg_q.ctr_on;
  assign sched_one = buf3 && cfg_q.auto_trg[3];
  // scheduled start yields to a same-cycle manual or access trigger
  assign fire_pend = !busy_q && (pend_q || sched_rep || sched_one) && (cfg_q.src != 2'd0) &&
                     !man_ok && !acc_trig && !abort_w;
  assign go        = man_ok || acc_trig || fire_pend;

  assign src_sel = man_ok ? cmd_i[1:0] : cfg_q.src;

  always_comb begin
    unique case (src_sel)
      2'd1:    opnd_d = txt_nxt_i;
      2'd2:    opnd_d = buf_nxt_i;
      default: opnd_d = txt_nxt_i ^ buf_nxt_i;
    endcase
  end

  assign guard_o   = guarded;
  assign key_we_o  = wr && (rg_i == RG_KEY);
  assign txt_we_o  = wr && (rg_i == RG_TXT);
  assign txx_we_o  = wr && (rg_i == RG_TXX);
  assign buf_we_o  = wr && (rg_i == RG_BUF);
  assign fold_o    = rd && last_i && ((cfg_q.fold[0] && rg_i == RG_TXT) ||
                                      (cfg_q.fold[1] && rg_i == RG_MIX));
  assign txt_clr_o = abort_w || (cmd_wr && cmd_i[CMD_CLRT] && !busy_q);
  assign buf_clr_o = abort_w || (cmd_wr && cmd_i[CMD_CLRB] && !busy_q);
  assign res_ld_o  = done_i && busy_q && !abort_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      full_q  <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      cfg_q   <= '0;
      opnd_q  <= '0;
    end else if (abort_w) begin
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      full_q  <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b1;
      cfg_q   <= '0;
    end else begin
      start_q <= go;
      done_q  <= done_i && busy_q;
      abort_q <= 1'b0;
      if (go)                  busy_q <= 1'b1;
      else if (done_i)         busy_q <= 1'b0;
      if (fire_pend)           pend_q <= 1'b0;
      else if (sched_rep || sched_one) pend_q <= 1'b1;
      if (fire_pend)           full_q <= 1'b0;
      else if (sched_one)      full_q <= 1'b1;
      if (wr && rg_i == RG_CFG) cfg_q <= cmd_i;
      else if (sched_one)      cfg_q.auto_trg[3] <= 1'b0;
      if (go)                  opnd_q <= opnd_d;
    end
  end

  assign start_o    = start_q;
  assign operand_o  = opnd_q;
  assign done_evt_o = done_q;
  assign abort_o    = abort_q;
  assign busy_o     = busy_q;
  assign full_o     = full_q;
  assign cfg_o      = cfg_q;

  assert_start_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_q);
  assert_start_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  assert_rise_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> start_o);
  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && busy_q) |=> !busy_q);
  assert_full_pend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> pend_q);
  assert_abort_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (!busy_q && !pend_q && cfg_q == '0));
endmodule

// File: rtl/aes_opr_top.sv
module aes_opr_top
  import aes_opr_pkg::*;
#(
  parameter  int unsigned DATA_W  = DW,
  parameter  int unsigned N_WORDS = NW,
  localparam int unsigned BLK_W   = DATA_W * N_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              start_o,
  output logic [BLK_W-1:0]  key_o,
  output logic [BLK_W-1:0]  operand_o,
  input  logic              done_i,
  input  logic [BLK_W-1:0]  result_i,
  output logic              done_evt_o,
  output logic              abort_o
);
  dec_t dec;
  cfg_t cfg;
  logic guard, key_we, txt_we, txx_we, buf_we, fold, txt_clr, buf_clr, res_ld, busy, full;
  logic [BLK_W-1:0] txt, bufv, txt_nxt, buf_nxt;

  aes_opr_decode u_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  aes_opr_ctrl #(.BLK_W(BLK_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .rg_i       (dec.rg),
    .last_i     (dec.last),
    .cmd_i      (wdata_i[CFG_W-1:0]),
    .done_i     (done_i),
    .txt_nxt_i  (txt_nxt),
    .buf_nxt_i  (buf_nxt),
    .ready_o    (ready_o),
    .guard_o    (guard),
    .key_we_o   (key_we),
    .txt_we_o   (txt_we),
    .txx_we_o   (txx_we),
    .buf_we_o   (buf_we),
    .fold_o     (fold),
    .txt_clr_o  (txt_clr),
    .buf_clr_o  (buf_clr),
    .res_ld_o   (res_ld),
    .start_o    (start_o),
    .operand_o  (operand_o),
    .done_evt_o (done_evt_o),
    .abort_o    (abort_o),
    .busy_o     (busy),
    .full_o     (full),
    .cfg_o      (cfg)
  );

  aes_opr_store #(.DATA_W(DATA_W), .N_WORDS(N_WORDS)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (dec.idx),
    .wdata_i   (wdata_i),
    .key_we_i  (key_we),
    .txt_we_i  (txt_we),
    .txx_we_i  (txx_we),
    .buf_we_i  (buf_we),
    .fold_i    (fold),
    .txt_clr_i (txt_clr),
    .buf_clr_i (buf_clr),
    .res_ld_i  (res_ld),
    .res_i     (result_i),
    .key_o     (key_o),
    .txt_o     (txt),
    .buf_o     (bufv),
    .txt_nxt_o (txt_nxt),
    .buf_nxt_o (buf_nxt)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && !guard) begin
      unique case (dec.rg)
        RG_TXT:  rdata_o = txt[dec.idx * DATA_W +: DATA_W];
        RG_BUF:  rdata_o = bufv[dec.idx * DATA_W +: DATA_W];
        RG_MIX:  rdata_o = txt[dec.idx * DATA_W +: DATA_W] ^ bufv[dec.idx * DATA_W +: DATA_W];
        RG_CFG:  rdata_o = DATA_W'(cfg);
        RG_STA:  rdata_o = DATA_W'({full, busy});
        default: rdata_o = '0;
      endcase
    end
  end

  assert_stall_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> busy);
  assert_key_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && dec.rg == RG_KEY && busy && ready_o) |=> $stable(key_o));
  assert_mix_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && dec.rg == RG_MIX && !cfg.fold[1] && !busy && !done_i) |=> $stable(txt));
endmodule

// File: tb/tb_aes_opr_top.sv
module tb_aes_opr_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0, we_i = 1'b0, done_i = 1'b0;
  logic [4:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [127:0] result_i = '0;
  logic [31:0]  rdata_o;
  logic         ready_o, start_o, done_evt_o, abort_o;
  logic [127:0] key_o, operand_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  aes_opr_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ready_o(ready_o), .start_o(start_o),
    .key_o(key_o), .operand_o(operand_o), .done_i(done_i), .result_i(result_i),
    .done_evt_o(done_evt_o), .abort_o(abort_o)
  );

  typedef struct packed {
    logic        we;
    logic [4:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'h04, 32'h11111111, 32'h0, 4'd4},         // R4 text words
    '{1'b1, 5'h05, 32'h22222222, 32'h0, 4'd4},
    '{1'b1, 5'h06, 32'h33333333, 32'h0, 4'd4},
    '{1'b1, 5'h07, 32'h44444444, 32'h0, 4'd4},
    '{1'b0, 5'h04, 32'h0, 32'h11111111, 4'd4},
    '{1'b1, 5'h08, 32'h0000FFFF, 32'h0, 4'd3},         // R3 xor window
    '{1'b0, 5'h04, 32'h0, 32'h1111EEEE, 4'd3},
    '{1'b0, 5'h05, 32'h0, 32'h22222222, 4'd3},
    '{1'b1, 5'h0C, 32'hF0F0F0F0, 32'h0, 4'd4},
    '{1'b1, 5'h0F, 32'h0F0F0F0F, 32'h0, 4'd4},
    '{1'b0, 5'h10, 32'h0, 32'hE1E11E1E, 4'd4},         // R4 mix window
    '{1'b0, 5'h04, 32'h0, 32'h1111EEEE, 4'd4},
    '{1'b0, 5'h0C, 32'h0, 32'hF0F0F0F0, 4'd4},
    '{1'b0, 5'h13, 32'h0, 32'h4B4B4B4B, 4'd4},
    '{1'b1, 5'h00, 32'hA5A5A5A5, 32'h0, 4'd13},        // R13 key write-only
    '{1'b0, 5'h00, 32'h0, 32'h0, 4'd13},
    '{1'b1, 5'h15, 32'h00000230, 32'h0, 4'd5},         // R5 config readback
    '{1'b0, 5'h15, 32'h0, 32'h00000230, 4'd5},
    '{1'b1, 5'h15, 32'h0, 32'h0, 4'd5},
    '{1'b0, 5'h16, 32'h0, 32'h0, 4'd1}
  };

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the accepting edge
  task automatic bus(input logic w, input logic [4:0] a, input logic [31:0] d,
                     output logic [31:0] q);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    #1;
    while (!ready_o) @(negedge clk_i);
    q = rdata_o;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus(1'b1, a, d, q);
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] e);
    logic [31:0] q;
    bus(1'b0, a, 32'h0, q);
    chk(tag, {96'h0, q}, {96'h0, e});
  endtask

  task automatic core_done(input logic [127:0] r);
    done_i = 1'b1; result_i = r;
    @(negedge clk_i);
    done_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state
    chk("R1 reset start", {127'h0, start_o}, 128'h0);
    chk("R10 reset ready", {127'h0, ready_o}, 128'h1);
    chk("R13 reset key", key_o, 128'h0);
    rd_chk("R1 reset status", 5'h16, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] qq;
      bus(VEC[i].we, VEC[i].a, VEC[i].d, qq);
      if (!VEC[i].we) chk($sformatf("R%0d vector %0d", VEC[i].rq, i), {96'h0, qq}, {96'h0, VEC[i].e});
      chk($sformatf("R5 no start on vector %0d", i), {127'h0, start_o}, 128'h0);
    end

    // R13 key mapping
    wr(5'h01, 32'hB0B0B0B0); wr(5'h02, 32'hC0C0C0C0); wr(5'h03, 32'hD0D0D0D0);
    chk("R13 key words", key_o, 128'hD0D0D0D0_C0C0C0C0_B0B0B0B0_A5A5A5A5);

    // R1 manual code 3
    wr(5'h14, 32'h3);
    chk("R1 start pulse", {127'h0, start_o}, 128'h1);
    chk("R1 operand txt^buf", operand_o, 128'h4B4B4B4B_33333333_22222222_E1E11E1E);
    rd_chk("R1 busy status", 5'h16, 32'h1);
    chk("R1 start one cycle", {127'h0, start_o}, 128'h0);

    // R9 drops while busy, stall off
    wr(5'h04, 32'hDEADBEEF);
    rd_chk("R9 text read zero", 5'h04, 32'h0);
    rd_chk("R9 mix read zero", 5'h10, 32'h0);
    wr(5'h00, 32'h12345678);
    chk("R9 key write dropped", key_o, 128'hD0D0D0D0_C0C0C0C0_B0B0B0B0_A5A5A5A5);
    wr(5'h0D, 32'h77777777);
    rd_chk("R9 buffer open when not full", 5'h0D, 32'h77777777);
    wr(5'h14, 32'h8);
    rd_chk("R11 clear ignored while busy", 5'h0C, 32'hF0F0F0F0);
    wr(5'h14, 32'h1);
    chk("R1 code ignored while busy", {127'h0, start_o}, 128'h0);

    // R2 completion
    core_done(128'hFEDCBA98_76543210_0F1E2D3C_4B5A6978);
    chk("R2 done event", {127'h0, done_evt_o}, 128'h1);
    rd_chk("R2 result in text", 5'h04, 32'h4B5A6978);
    chk("R2 done event one cycle", {127'h0, done_evt_o}, 128'h0);
    chk("R2 key kept", key_o, 128'hD0D0D0D0_C0C0C0C0_B0B0B0B0_A5A5A5A5);
    rd_chk("R2 idle status", 5'h16, 32'h0);
    rd_chk("R3 dropped text write not applied", 5'h07, 32'hFEDCBA98);

    // R11 clears while idle
    wr(5'h14, 32'h4);
    rd_chk("R11 text cleared", 5'h07, 32'h0);
    rd_chk("R11 buffer kept", 5'h0C, 32'hF0F0F0F0);
    wr(5'h14, 32'h8);
    rd_chk("R11 buffer cleared", 5'h0C, 32'h0);
    rd_chk("R11 buffer word1 cleared", 5'h0D, 32'h0);
    wr(5'h14, 32'h0);
    chk("R1 code 0 ignored", {127'h0, start_o}, 128'h0);

    // R5 auto bit0: writes to word 3
    wr(5'h15, 32'h11);
    wr(5'h04, 32'h00000001);
    chk("R5 word0 no start", {127'h0, start_o}, 128'h0);
    wr(5'h07, 32'hAAAA0000);
    chk("R5 write word3 start", {127'h0, start_o}, 128'h1);
    chk("R5 write word3 operand", operand_o, 128'hAAAA0000_00000000_00000000_00000001);
    core_done(128'hC3);
    // R5 auto bit1: read of word 3
    wr(5'h15, 32'h12);
    rd_chk("R5 read word3 data", 5'h07, 32'h0);
    chk("R5 read word3 start", {127'h0, start_o}, 128'h1);
    chk("R5 read word3 operand", operand_o, 128'hC3);
    core_done(128'h5);

    // R8 fold on read
    wr(5'h0C, 32'h30);
    wr(5'h15, 32'h40);
    rd_chk("R8 fold read returns old", 5'h07, 32'h0);
    rd_chk("R8 fold on text word3", 5'h04, 32'h35);
    wr(5'h15, 32'h80);
    rd_chk("R8 fold via mix word3", 5'h13, 32'h0);
    rd_chk("R8 fold bit1 applied", 5'h04, 32'h05);
    rd_chk("R8 no fold on text word3", 5'h07, 32'h0);
    rd_chk("R8 text unchanged", 5'h04, 32'h05);

    // R6 repeated buffer word 3 schedule
    wr(5'h15, 32'h24);
    wr(5'h0F, 32'h99);
    chk("R6 idle immediate start", {127'h0, start_o}, 128'h1);
    chk("R6 operand buffer", operand_o, 128'h99_00000000_00000000_00000030);
    rd_chk("R6 status busy not full", 5'h16, 32'h1);
    wr(5'h0F, 32'h88);
    chk("R6 no start while busy", {127'h0, start_o}, 128'h0);
    core_done(128'h0);
    chk("R2 done event R6", {127'h0, done_evt_o}, 128'h1);
    @(negedge clk_i);
    chk("R6 scheduled start after idle", {127'h0, start_o}, 128'h1);
    chk("R6 scheduled operand", operand_o, 128'h88_00000000_00000000_00000030);
    core_done(128'h0);
    @(negedge clk_i);
    wr(5'h15, 32'h224);
    wr(5'h0F, 32'h11);
    chk("R6 counter mode suppresses", {127'h0, start_o}, 128'h0);
    rd_chk("R6 counter mode idle", 5'h16, 32'h0);

    // R7 single shot with buffer full
    wr(5'h15, 32'h28);
    wr(5'h14, 32'h2);
    chk("R1 manual code 2 operand", operand_o, 128'h11_00000000_00000000_00000030);
    wr(5'h0F, 32'h77);
    rd_chk("R7 busy and full", 5'h16, 32'h3);
    rd_chk("R7 bit3 self-cleared", 5'h15, 32'h20);
    wr(5'h0C, 32'h1234);
    rd_chk("R9 full buffer read zero", 5'h0C, 32'h0);
    core_done(128'h0);
    @(negedge clk_i);
    chk("R7 single start fires", {127'h0, start_o}, 128'h1);
    chk("R7 operand, full write dropped", operand_o, 128'h77_00000000_00000000_00000030);
    rd_chk("R7 full cleared on take", 5'h16, 32'h1);
    core_done(128'h0);
    @(negedge clk_i);
    wr(5'h0F, 32'h66);
    chk("R7 later write no start", {127'h0, start_o}, 128'h0);
    rd_chk("R7 idle status", 5'h16, 32'h0);

    // R10 stall mode
    wr(5'h15, 32'h110);
    wr(5'h14, 32'h1);
    chk("R10 started", {127'h0, start_o}, 128'h1);
    fork
      bus(1'b0, 5'h04, 32'h0, q);
      begin
        @(negedge clk_i);
        chk("R10 ready low 1", {127'h0, ready_o}, 128'h0);
        @(negedge clk_i);
        chk("R10 ready low 2", {127'h0, ready_o}, 128'h0);
        core_done(128'h9_00000000_00000000_ABCD0123);
      end
    join
    chk("R10 stalled read data", {96'h0, q}, {96'h0, 32'hABCD0123});

    // R12 abort
    wr(5'h04, 32'h55);
    wr(5'h14, 32'h1);
    wr(5'h14, 32'h10);
    chk("R12 abort pulse", {127'h0, abort_o}, 128'h1);
    rd_chk("R12 status cleared", 5'h16, 32'h0);
    chk("R12 abort one cycle", {127'h0, abort_o}, 128'h0);
    rd_chk("R12 config cleared", 5'h15, 32'h0);
    rd_chk("R12 text cleared", 5'h04, 32'h0);
    rd_chk("R12 buffer cleared", 5'h0C, 32'h0);
    core_done(128'h1);
    chk("R12 late done ignored", {127'h0, done_evt_o}, 128'h0);
    rd_chk("R12 text not loaded", 5'h04, 32'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule